// File: doc/BRIEF.md
# Multi-Context Lookup Cell

This block is one logic cell of a gate array whose function can change from one clock cycle to the next. The cell evaluates a 4-input lookup table: the input bits form an index into a 16-bit truth table, and the selected bit is the cell's output. The cell holds several truth tables, one per context. A context number shared by every cell in the array chooses which table is live, so each cell computes its own function under a given context, and the whole array switches function when the context changes.

The output is available directly as a combinational value. It can also be captured into a local state bit under an enable. A separate write port loads a truth table into any plane that is not currently live, so a later context can be prepared while the cell keeps computing. A write aimed at the live plane, or at a plane number that does not exist, is refused. It is reported with a one-cycle error pulse and leaves the stored table unchanged. The context number is registered: a new value presented on a clock edge becomes live from the next cycle onward.

Top module: `mctx_lut_cell`

## Requirements
- R1: After reset, every plane holds zero, the live context is 0, `reg_out` is 0 and `cfg_err` is 0, so `comb_out` is 0 for every input value.
- R2: `comb_out` equals bit number `lut_in` (bit 0 for input value 0, bit 15 for input value 15) of the live plane, with no clock edge in between.
- R3: A `ctx_sel` value below `N_CTX` present at a rising edge becomes the live context from that edge on.
- R4: A `ctx_sel` value of `N_CTX` or above is ignored, and the live context keeps its previous value.
- R5: A write with `cfg_we` high to a plane number below `N_CTX` that is not the live context stores `cfg_tt` into that plane at the edge. While that plane is not live, the write does not change `comb_out`.
- R6: A write aimed at the live context leaves that plane unchanged and raises `cfg_err` for exactly the cycle after the edge.
- R7: A write aimed at a plane number of `N_CTX` or above is discarded and raises `cfg_err` for the cycle after the edge.
- R8: When `ctx_sel` moves to plane k at the same edge as an accepted write to plane k, the new table is stored before the switch, and `comb_out` follows the new table from the next cycle.
- R9: With `reg_en` high at an edge, `reg_out` takes the `comb_out` value present before that edge. With `reg_en` low, `reg_out` holds.
- R10: `cfg_err` is low in every cycle that does not follow a refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctx_sel | input | CTX_W | Context number shared across the array |
| lut_in | input | LUT_IN | Lookup index (the cell's data inputs) |
| reg_en | input | 1 | Capture enable for the local state bit |
| comb_out | output | 1 | Combinational lookup result from the live plane |
| reg_out | output | 1 | Registered lookup result |
| cfg_we | input | 1 | Truth-table write strobe |
| cfg_ctx | input | CTX_W | Plane number the write targets |
| cfg_tt | input | 2**LUT_IN | Truth table to store |
| cfg_err | output | 1 | One-cycle pulse after a refused write |

## Verification
`comb_out` is due in the same cycle as a change of `lut_in`. A change of context or truth table reaches `comb_out` one edge after it is presented. `reg_out` and `cfg_err` are due one edge after the stimulus that causes them. The bench drives every input on the falling edge and checks `comb_out` two nanoseconds later, within that same half cycle. It then updates its own model at the next rising edge and checks `reg_out` and `cfg_err` at the falling edge that follows, so each result is sampled in the cycle it is due and never at an edge. The bench runs with three contexts, so one context code is out of range and the R4 and R7 paths are exercised.

// File: rtl/mctx_pkg.sv
package mctx_pkg;

    // Outcome of a configuration write request in the current cycle
    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_TAKE   = 2'd1,
        WR_REFUSE = 2'd2
    } wr_verdict_e;

    // Width of a context number for a given context count (at least one bit)
    function automatic int unsigned ctx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mctx_wr_gate.sv
module mctx_wr_gate #(
    parameter int N_CTX = 2,
    parameter int CTX_W = 1
) (
    input  logic                     cfg_we,
    input  logic [CTX_W-1:0]         cfg_ctx,
    input  logic [CTX_W-1:0]         act_ctx,
    output mctx_pkg::wr_verdict_e    verdict,
    output logic [N_CTX-1:0]         plane_we
);
    import mctx_pkg::*;

    logic in_range;

    always_comb begin
        in_range = (32'(cfg_ctx) < N_CTX);
        verdict  = WR_IDLE;
        if (cfg_we) begin
            if (!in_range || (cfg_ctx == act_ctx)) begin
                verdict = WR_REFUSE;
            end else begin
                verdict = WR_TAKE;
            end
        end
    end

    for (genvar g = 0; g < N_CTX; g++) begin : g_we
        assign plane_we[g] = (verdict == WR_TAKE) && (cfg_ctx == CTX_W'(g));
    end

endmodule

// File: rtl/mctx_plane_store.sv
module mctx_plane_store #(
    parameter int N_CTX = 2,
    parameter int TT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CTX-1:0]         plane_we,
    input  logic [TT_W-1:0]          wr_tt,
    output logic [N_CTX*TT_W-1:0]    planes_flat
);

    for (genvar g = 0; g < N_CTX; g++) begin : g_plane
        logic [TT_W-1:0] tt_d, tt_q;

        always_comb begin
            tt_d = tt_q;
            if (plane_we[g]) begin
                tt_d = wr_tt;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tt_q <= '0;
            end else begin
                tt_q <= tt_d;
            end
        end

        assign planes_flat[g*TT_W +: TT_W] = tt_q;
    end

endmodule

// File: rtl/mctx_lut_eval.sv
module mctx_lut_eval #(
    parameter int N_CTX  = 2,
    parameter int LUT_IN = 4,
    parameter int CTX_W  = 1
) (
    input  logic [N_CTX*(2**LUT_IN)-1:0] planes_flat,
    input  logic [CTX_W-1:0]             act_ctx,
    input  logic [LUT_IN-1:0]            lut_in,
    output logic                         lut_out
);
    localparam int TT_W = 2**LUT_IN;

    logic [TT_W-1:0] live_tt;

    always_comb begin
        live_tt = '0;
        for (int i = 0; i < N_CTX; i++) begin
            if (act_ctx == CTX_W'(i)) begin
                live_tt = planes_flat[i*TT_W +: TT_W];
            end
        end
        lut_out = live_tt[lut_in];
    end

endmodule

// File: rtl/mctx_lut_cell.sv
module mctx_lut_cell #(
    parameter int N_CTX  = 2,
    parameter int LUT_IN = 4,
    parameter int CTX_W  = mctx_pkg::ctx_bits(N_CTX),
    parameter int TT_W   = 2**LUT_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTX_W-1:0]  ctx_sel,
    input  logic [LUT_IN-1:0] lut_in,
    input  logic              reg_en,
    output logic              comb_out,
    output logic              reg_out,
    input  logic              cfg_we,
    input  logic [CTX_W-1:0]  cfg_ctx,
    input  logic [TT_W-1:0]   cfg_tt,
    output logic              cfg_err
);
    import mctx_pkg::*;

    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic             rout;
        logic             err;
    } cell_st_t;

    cell_st_t                  st_d, st_q;
    wr_verdict_e               verdict;
    logic [N_CTX-1:0]          plane_we;
    logic [N_CTX*TT_W-1:0]     planes_flat;
    logic [CTX_W-1:0]          act_ctx;
    logic                      lut_val;

    assign act_ctx = st_q.ctx;

    mctx_wr_gate #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_wr_gate (
        .cfg_we   (cfg_we),
        .cfg_ctx  (cfg_ctx),
        .act_ctx  (act_ctx),
        .verdict  (verdict),
        .plane_we (plane_we)
    );

    mctx_plane_store #(.N_CTX(N_CTX), .TT_W(TT_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .plane_we    (plane_we),
        .wr_tt       (cfg_tt),
        .planes_flat (planes_flat)
    );

    mctx_lut_eval #(.N_CTX(N_CTX), .LUT_IN(LUT_IN), .CTX_W(CTX_W)) u_eval (
        .planes_flat (planes_flat),
        .act_ctx     (act_ctx),
        .lut_in      (lut_in),
        .lut_out     (lut_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = (verdict == WR_REFUSE);
        if (32'(ctx_sel) < N_CTX) begin
            st_d.ctx = ctx_sel;
        end
        if (reg_en) begin
            st_d.rout = lut_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign comb_out = lut_val;
    assign reg_out  = st_q.rout;
    assign cfg_err  = st_q.err;

endmodule

// File: rtl/mctx_lut_cell_chk.sv
module mctx_lut_cell_chk #(
    parameter int N_CTX  = 2,
    parameter int LUT_IN = 4,
    parameter int CTX_W  = mctx_pkg::ctx_bits(N_CTX),
    parameter int TT_W   = 2**LUT_IN
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CTX_W-1:0]       ctx_sel,
    input logic                   reg_en,
    input logic                   comb_out,
    input logic                   reg_out,
    input logic                   cfg_we,
    input logic [CTX_W-1:0]       cfg_ctx,
    input logic                   cfg_err,
    input logic [CTX_W-1:0]       act_ctx,
    input logic [N_CTX*TT_W-1:0]  planes_flat
);
    logic [TT_W-1:0]  live_plane, guard_now;
    logic [TT_W-1:0]  guard_q;
    logic [CTX_W-1:0] guard_ctx_q;

    always_comb begin
        live_plane = '0;
        guard_now  = '0;
        for (int i = 0; i < N_CTX; i++) begin
            if (act_ctx == CTX_W'(i))     live_plane = planes_flat[i*TT_W +: TT_W];
            if (guard_ctx_q == CTX_W'(i)) guard_now  = planes_flat[i*TT_W +: TT_W];
        end
    end

    // Copy of the previous cycle's live plane, for the write-protection check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q     <= '0;
            guard_ctx_q <= '0;
        end else begin
            guard_q     <= live_plane;
            guard_ctx_q <= act_ctx;
        end
    end

    AST_CTX_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(ctx_sel) < N_CTX) |=> (act_ctx == $past(ctx_sel))); // R3
    AST_CTX_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(ctx_sel) >= N_CTX) |=> $stable(act_ctx)); // R4
    AST_LIVE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_ctx == act_ctx)) |=> (guard_now == guard_q)); // R6
    AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ((cfg_ctx == act_ctx) || (32'(cfg_ctx) >= N_CTX))) |=> cfg_err); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we)); // R10
    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |=> (reg_out == $past(comb_out))); // R9
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> $stable(reg_out)); // R9

endmodule

bind mctx_lut_cell mctx_lut_cell_chk #(.N_CTX(N_CTX), .LUT_IN(LUT_IN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctx_sel     (ctx_sel),
    .reg_en      (reg_en),
    .comb_out    (comb_out),
    .reg_out     (reg_out),
    .cfg_we      (cfg_we),
    .cfg_ctx     (cfg_ctx),
    .cfg_err     (cfg_err),
    .act_ctx     (act_ctx),
    .planes_flat (planes_flat)
);

// File: tb/mctx_lut_cell_bench.sv
module mctx_lut_cell_bench;
    localparam int N_CTX  = 3;
    localparam int LUT_IN = 4;
    localparam int CTX_W  = 2;
    localparam int TT_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CTX_W-1:0]  ctx_sel = '0;
    logic [LUT_IN-1:0] lut_in = '0;
    logic              reg_en = 1'b0;
    logic              comb_out, reg_out, cfg_err;
    logic              cfg_we = 1'b0;
    logic [CTX_W-1:0]  cfg_ctx = '0;
    logic [TT_W-1:0]   cfg_tt = '0;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model, written from the requirements
    logic [TT_W-1:0] m_plane [N_CTX];
    int              m_act = 0;
    logic            m_reg = 1'b0;

    always #10 clk = ~clk;

    mctx_lut_cell #(.N_CTX(N_CTX), .LUT_IN(LUT_IN)) u_mctx_lut_cell (
        .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .lut_in(lut_in),
        .reg_en(reg_en), .comb_out(comb_out), .reg_out(reg_out),
        .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_tt(cfg_tt), .cfg_err(cfg_err)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // One cycle: drive at the falling edge, check comb_out, step the model at
    // the rising edge, then check the registered outputs at the next falling edge.
    task automatic cyc(input int c, input logic we, input int wc, input logic [15:0] tt,
                       input logic en, input int x, input string tag);
        logic exp_comb, exp_err;
        string etag;
        ctx_sel = CTX_W'(c);
        cfg_we  = we;
        cfg_ctx = CTX_W'(wc);
        cfg_tt  = tt;
        reg_en  = en;
        lut_in  = LUT_IN'(x);
        #2;
        exp_comb = m_plane[m_act][x];
        chk(comb_out, exp_comb, tag, "comb_out");
        exp_err = we && ((wc >= N_CTX) || (wc == m_act));
        if (we && wc >= N_CTX)      etag = "R7";
        else if (we && wc == m_act) etag = "R6";
        else                        etag = "R10";
        @(posedge clk);
        if (we && !exp_err) m_plane[wc] = tt;
        if (en) m_reg = exp_comb;
        if (c < N_CTX) m_act = c;
        @(negedge clk);
        chk(reg_out, m_reg, "R9", "reg_out");
        chk(cfg_err, exp_err, etag, "cfg_err");
    endtask

    initial begin
        for (int i = 0; i < N_CTX; i++) m_plane[i] = '0;
        // R1: state held in reset
        repeat (3) @(negedge clk);
        for (int x = 0; x < 16; x += 5) begin
            lut_in = LUT_IN'(x);
            #2;
            chk(comb_out, 1'b0, "R1", "comb_out in reset");
        end
        chk(reg_out, 1'b0, "R1", "reg_out in reset");
        chk(cfg_err, 1'b0, "R1", "cfg_err in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every plane reads zero after reset
        for (int c = 0; c < N_CTX; c++)
            for (int x = 0; x < 16; x++)
                cyc(c, 1'b0, 0, 16'h0, x[0], x, "R1");

        // R5: load the idle planes while context 0 is live
        cyc(0, 1'b1, 1, 16'h6996, 1'b0, 3, "R5");
        cyc(0, 1'b1, 2, 16'h8001, 1'b0, 7, "R5");
        // R6: write to the live plane is refused
        cyc(0, 1'b1, 0, 16'hFFFF, 1'b1, 9, "R6");
        cyc(0, 1'b0, 0, 16'h0, 1'b1, 9, "R6");
        // R7: plane number out of range is refused
        cyc(0, 1'b1, 3, 16'h1234, 1'b0, 1, "R7");
        // load plane 0 from another context
        cyc(1, 1'b0, 0, 16'h0, 1'b0, 0, "R3");
        cyc(1, 1'b1, 0, 16'hC3A5, 1'b0, 0, "R5");

        // R2 / R3 / R9: exhaustive sweep of every plane with varied enables
        for (int c = 0; c < N_CTX; c++)
            for (int x = 0; x < 16; x++)
                cyc(c, 1'b0, 0, 16'h0, (x % 3) != 0, x, "R2");

        // R4: out-of-range context keeps the live one (plane 2 live here)
        for (int x = 0; x < 16; x++)
            cyc(3, 1'b0, 0, 16'h0, 1'b1, x, "R4");

        // R8: switch to a plane and overwrite it in the same cycle
        cyc(0, 1'b1, 0, 16'h0F0F, 1'b0, 4, "R8");
        for (int x = 0; x < 16; x++)
            cyc(0, 1'b0, 0, 16'h0, 1'b1, x, "R8");
        cyc(1, 1'b1, 1, 16'hAAAA, 1'b1, 5, "R8");
        for (int x = 0; x < 16; x++)
            cyc(1, 1'b0, 0, 16'h0, x[1], x, "R8");

        // R5 / R6: background writes while the cell runs, targets rotating
        for (int k = 0; k < 48; k++)
            cyc(k % N_CTX, 1'b1, (k * 2 + 1) % 4, 16'(k * 16'h1357 + 16'h2468),
                k[0], (k * 7) % 16, "R5");

        // R10 / R9: idle stretch with the enable low holds reg_out
        for (int x = 0; x < 16; x++)
            cyc(x % N_CTX, 1'b0, 0, 16'h0, 1'b0, x, "R10");

        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

endmodule